// File: doc/BRIEF.md
# Operand Bypass and Load-Dependency Stall Control

This block is the combinational hazard controller of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It compares each source register index of the instruction now in execute with the destination indices held further down the pipeline. For each of the two ALU inputs it then chooses where the operand comes from: the register file, the ALU result waiting in the execute/memory buffer, or one of the two values waiting in the memory/write-back buffer. Those two are the ALU result and the loaded data. Results that have not yet been written back therefore reach the ALU without delay. A dependent ALU instruction can follow its producer with no gap.

The controller also looks at the instruction in decode. If that instruction reads the register that a load now in execute will fill, the data cannot exist in time. The block then raises a single stall. The program counter and the fetch/decode buffer hold their contents, and the decode/execute buffer takes a bubble. On the next cycle the load has moved on to the memory stage and the stall clears by itself. One cycle later the dependent instruction reaches execute and takes the load data from the write-back buffer. The load-use penalty is one cycle. Write-after-read and write-after-write orderings need no handling, because every instruction reads in decode and writes in the last stage, in program order.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory buffer holds a register-writing instruction whose nonzero destination equals an execute source index, that operand's select is 1 (execute/memory ALU result).
- R2: When only the memory/write-back buffer matches a source, the select is 2 (write-back ALU result) if that instruction is not a load, and 3 (write-back load data) if it is a load.
- R3: When both buffers match the same source, the select is 1: the newer value wins.
- R4: A select is 0 (register file) when no buffer matches. A buffer whose write enable is low (store, branch, bubble) never matches, and neither does register index 0.
- R5: The two operand selects are decided independently. Input A uses `selA` and input B uses `selB`, and both may forward in the same cycle.
- R6: The stall is raised when execute holds a register-writing load with a nonzero destination, and decode reads that destination through a source whose use flag is high.
- R7: No stall is raised when the matching decode source is not used, when execute holds no load, or when the load destination is register 0.
- R8: `pcHold`, `ifdHold` and `exBubble` are always equal.
- R9: In a load followed directly by a dependent instruction, exactly one stall cycle occurs. When the dependent instruction reaches execute, its operand select is 3.
- R10: In an ALU instruction followed directly by a dependent ALU instruction, no stall occurs and the dependent operand select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| idSrcA | input | REG_W | Source A index of the instruction in decode |
| idSrcB | input | REG_W | Source B index of the instruction in decode |
| idUseA | input | 1 | Decode instruction reads source A |
| idUseB | input | 1 | Decode instruction reads source B |
| exSrcA | input | REG_W | Source A index of the instruction in execute |
| exSrcB | input | REG_W | Source B index of the instruction in execute |
| exDst | input | REG_W | Destination index of the instruction in execute |
| exWrEn | input | 1 | Execute instruction writes a register |
| exIsLoad | input | 1 | Execute instruction is a load |
| memDst | input | REG_W | Destination index in the execute/memory buffer |
| memWrEn | input | 1 | Execute/memory instruction writes a register |
| wbDst | input | REG_W | Destination index in the memory/write-back buffer |
| wbWrEn | input | 1 | Memory/write-back instruction writes a register |
| wbIsLoad | input | 1 | Memory/write-back instruction is a load |
| selA | output | 2 | ALU input A source: 0 register file, 1 execute/memory result, 2 write-back ALU result, 3 write-back load data |
| selB | output | 2 | ALU input B source, same encoding |
| pcHold | output | 1 | Hold the program counter |
| ifdHold | output | 1 | Hold the fetch/decode buffer |
| exBubble | output | 1 | Load a bubble into the decode/execute buffer |

## Verification
Forwarding to the execute instruction and the load-use stall for the decode instruction can fall in the same cycle. The bench provokes this with a load in execute whose decode successor depends on it, while the load's own base register is produced by the ALU instruction one stage ahead. It expects select 1 on the load's operand and all three stall strobes high in that cycle, so the two decisions are shown not to mask each other. The short instruction sequences then follow the stall and bubble through the pipeline cycle by cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  localparam int NUM_OPS = 2;

  typedef enum logic [1:0] {
    SEL_RF      = 2'd0,
    SEL_MEM_ALU = 2'd1,
    SEL_WB_ALU  = 2'd2,
    SEL_WB_LOAD = 2'd3
  } opSel_e;

  // Comparator results handed from the match datapath to the control
  typedef struct packed {
    logic [NUM_OPS-1:0] memHit;
    logic [NUM_OPS-1:0] wbHit;
    logic               loadUse;
  } hitVec_t;

  // Strobes from the control toward the pipeline registers
  typedef struct packed {
    logic pcHold;
    logic ifdHold;
    logic exBubble;
  } stallStrobe_t;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [NUM_OPS-1:0][REG_W-1:0] exSrc,
  input  logic [NUM_OPS-1:0][REG_W-1:0] idSrc,
  input  logic [NUM_OPS-1:0]            idUse,
  input  logic [REG_W-1:0]              exDst,
  input  logic                          exWrEn,
  input  logic                          exIsLoad,
  input  logic [REG_W-1:0]              memDst,
  input  logic                          memWrEn,
  input  logic [REG_W-1:0]              wbDst,
  input  logic                          wbWrEn,
  output hitVec_t                       hits
);

  localparam logic [REG_W-1:0] ZERO_REG = '0;

  // A producer counts only if it writes and does not target the zero register
  logic memLive;
  logic wbLive;
  logic ldLive;
  logic [NUM_OPS-1:0] useHit;

  assign memLive = memWrEn && (memDst != ZERO_REG);
  assign wbLive  = wbWrEn  && (wbDst  != ZERO_REG);
  assign ldLive  = exIsLoad && exWrEn && (exDst != ZERO_REG);

  for (genvar op = 0; op < NUM_OPS; op++) begin : g_op
    assign hits.memHit[op] = memLive && (exSrc[op] == memDst);
    assign hits.wbHit[op]  = wbLive  && (exSrc[op] == wbDst);
    assign useHit[op]      = idUse[op] && (idSrc[op] == exDst);
  end

  assign hits.loadUse = ldLive && (|useHit);

endmodule

// File: rtl/fwd_ctl.sv
module fwd_ctl
  import fwd_pkg::*;
(
  input  hitVec_t                hits,
  input  logic                   wbIsLoad,
  output opSel_e [NUM_OPS-1:0]   opSel,
  output stallStrobe_t           strobes
);

  opSel_e wbSel;
  assign wbSel = wbIsLoad ? SEL_WB_LOAD : SEL_WB_ALU;

  // Newest producer wins: execute/memory, then write-back, then register file
  for (genvar op = 0; op < NUM_OPS; op++) begin : g_sel
    always_comb begin
      if (hits.memHit[op])     opSel[op] = SEL_MEM_ALU;
      else if (hits.wbHit[op]) opSel[op] = wbSel;
      else                     opSel[op] = SEL_RF;
    end
  end

  always_comb begin
    strobes.pcHold   = hits.loadUse;
    strobes.ifdHold  = hits.loadUse;
    strobes.exBubble = hits.loadUse;
  end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [REG_W-1:0] idSrcA,
  input  logic [REG_W-1:0] idSrcB,
  input  logic             idUseA,
  input  logic             idUseB,
  input  logic [REG_W-1:0] exSrcA,
  input  logic [REG_W-1:0] exSrcB,
  input  logic [REG_W-1:0] exDst,
  input  logic             exWrEn,
  input  logic             exIsLoad,
  input  logic [REG_W-1:0] memDst,
  input  logic             memWrEn,
  input  logic [REG_W-1:0] wbDst,
  input  logic             wbWrEn,
  input  logic             wbIsLoad,
  output logic [1:0]       selA,
  output logic [1:0]       selB,
  output logic             pcHold,
  output logic             ifdHold,
  output logic             exBubble
);

  hitVec_t              hits;
  stallStrobe_t         strobes;
  opSel_e [NUM_OPS-1:0] opSel;

  fwd_match #(.REG_W(REG_W)) u_match (
    .exSrc    ({exSrcB, exSrcA}),
    .idSrc    ({idSrcB, idSrcA}),
    .idUse    ({idUseB, idUseA}),
    .exDst    (exDst),
    .exWrEn   (exWrEn),
    .exIsLoad (exIsLoad),
    .memDst   (memDst),
    .memWrEn  (memWrEn),
    .wbDst    (wbDst),
    .wbWrEn   (wbWrEn),
    .hits     (hits)
  );

  fwd_ctl u_ctl (
    .hits     (hits),
    .wbIsLoad (wbIsLoad),
    .opSel    (opSel),
    .strobes  (strobes)
  );

  assign selA     = opSel[0];
  assign selB     = opSel[1];
  assign pcHold   = strobes.pcHold;
  assign ifdHold  = strobes.ifdHold;
  assign exBubble = strobes.exBubble;

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int REG_W = 5
) (
  input logic [REG_W-1:0] idSrcA,
  input logic [REG_W-1:0] idSrcB,
  input logic             idUseA,
  input logic             idUseB,
  input logic [REG_W-1:0] exSrcA,
  input logic [REG_W-1:0] exSrcB,
  input logic [REG_W-1:0] exDst,
  input logic             exWrEn,
  input logic             exIsLoad,
  input logic [REG_W-1:0] memDst,
  input logic             memWrEn,
  input logic [REG_W-1:0] wbDst,
  input logic             wbWrEn,
  input logic             wbIsLoad,
  input logic [1:0]       selA,
  input logic [1:0]       selB,
  input logic             pcHold,
  input logic             ifdHold,
  input logic             exBubble
);

  logic known;
  assign known = !$isunknown({idSrcA, idSrcB, idUseA, idUseB, exSrcA, exSrcB, exDst,
                              exWrEn, exIsLoad, memDst, memWrEn, wbDst, wbWrEn, wbIsLoad});

  always_comb begin
    if (known) begin
      // R8
      strobe_agree_chk: assert (pcHold == ifdHold && ifdHold == exBubble)
        else $error("stall strobes disagree");
      // R3
      mem_prio_chk: assert (!(memWrEn && memDst != '0 && exSrcA == memDst) || selA == 2'd1)
        else $error("execute/memory match did not win on operand A");
      // R2
      load_sel_chk: assert (!(selA == 2'd3 || selB == 2'd3) || (wbIsLoad && wbWrEn))
        else $error("load data selected without a write-back load");
      // R4
      no_writer_chk: assert (memWrEn || wbWrEn || (selA == 2'd0 && selB == 2'd0))
        else $error("forwarded with no writing producer");
      // R7
      no_load_chk: assert (exIsLoad || !pcHold)
        else $error("stall without a load in execute");
    end
  end

endmodule

bind fwd_unit fwd_unit_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/fwd_unit_tb.sv
`timescale 1ns/1ps
module fwd_unit_tb;

  localparam int REG_W = 5;

  typedef struct packed {
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] a;
    logic [REG_W-1:0] b;
    logic useA;
    logic useB;
    logic ld;
    logic wr;
  } ins_t;

  typedef struct {
    logic [1:0] sA;
    logic [1:0] sB;
    logic       st;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [REG_W-1:0] idSrcA, idSrcB, exSrcA, exSrcB, exDst, memDst, wbDst;
  logic idUseA, idUseB, exWrEn, exIsLoad, memWrEn, wbWrEn, wbIsLoad;
  logic [1:0] selA, selB;
  logic pcHold, ifdHold, exBubble;

  fwd_unit #(.REG_W(REG_W)) u_dut (.*);

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int stallSeen = 0;
  bit done = 1'b0;

  function automatic ins_t mk(int dst, int a, int b, bit ua, bit ub, bit ld, bit wr);
    ins_t r;
    r.dst = REG_W'(dst); r.a = REG_W'(a); r.b = REG_W'(b);
    r.useA = ua; r.useB = ub; r.ld = ld; r.wr = wr;
    return r;
  endfunction

  localparam ins_t BUB = '0;

  // Driver: place instructions into the four stage slots and queue the expectation
  task automatic drive(ins_t idI, ins_t exI, ins_t memI, ins_t wbI,
                       logic [1:0] eA, logic [1:0] eB, logic eSt, string tag);
    exp_t e;
    @(posedge clk);
    #1;
    idSrcA = idI.a; idSrcB = idI.b; idUseA = idI.useA; idUseB = idI.useB;
    exSrcA = exI.a; exSrcB = exI.b; exDst = exI.dst; exWrEn = exI.wr; exIsLoad = exI.ld;
    memDst = memI.dst; memWrEn = memI.wr;
    wbDst = wbI.dst; wbWrEn = wbI.wr; wbIsLoad = wbI.ld;
    e.sA = eA; e.sB = eB; e.st = eSt; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: compare away from the driving edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, "selA", int'(selA), int'(e.sA));
      check(e.tag, "selB", int'(selB), int'(e.sB));
      check(e.tag, "pcHold", int'(pcHold), int'(e.st));
      check(e.tag, "ifdHold/R8", int'(ifdHold), int'(e.st));
      check(e.tag, "exBubble/R8", int'(exBubble), int'(e.st));
      if (pcHold) stallSeen++;
    end
  end

  initial begin
    int wd = 0;
    while (!done && wd < 5000) begin
      @(posedge clk);
      wd++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ins_t addA;
    int base;
    addA = mk(9, 3, 4, 1, 1, 0, 1);

    // idle pipeline of bubbles (R4)
    drive(BUB, BUB, BUB, BUB, 2'd0, 2'd0, 1'b0, "R4 idle");
    // R1: execute/memory result to operand A
    drive(BUB, addA, mk(3, 0, 0, 0, 0, 0, 1), BUB, 2'd1, 2'd0, 1'b0, "R1 memA");
    // R5: only operand B forwards
    drive(BUB, addA, mk(4, 0, 0, 0, 0, 0, 1), BUB, 2'd0, 2'd1, 1'b0, "R5 memB");
    // R2: write-back ALU result
    drive(BUB, addA, BUB, mk(3, 0, 0, 0, 0, 0, 1), 2'd2, 2'd0, 1'b0, "R2 wbAlu");
    // R2: write-back load data
    drive(BUB, addA, BUB, mk(4, 0, 0, 0, 0, 1, 1), 2'd0, 2'd3, 1'b0, "R2 wbLoad");
    // R3: both buffers match, newer wins
    drive(BUB, addA, mk(3, 0, 0, 0, 0, 0, 1), mk(3, 0, 0, 0, 0, 1, 1), 2'd1, 2'd0, 1'b0, "R3 prio");
    // R5: A and B forward from different buffers
    drive(BUB, addA, mk(4, 0, 0, 0, 0, 0, 1), mk(3, 0, 0, 0, 0, 0, 1), 2'd2, 2'd1, 1'b0, "R5 split");
    // R4: store in execute/memory does not write
    drive(BUB, addA, mk(3, 0, 0, 0, 0, 0, 0), mk(4, 0, 0, 0, 0, 0, 0), 2'd0, 2'd0, 1'b0, "R4 noWrite");
    // R4: register 0 never forwards
    drive(BUB, mk(9, 0, 0, 1, 1, 0, 1), mk(0, 0, 0, 0, 0, 0, 1), mk(0, 0, 0, 0, 0, 1, 1),
          2'd0, 2'd0, 1'b0, "R4 zeroReg");
    // R5: both sources name the same register
    drive(BUB, mk(9, 3, 3, 1, 1, 0, 1), mk(3, 0, 0, 0, 0, 0, 1), BUB, 2'd1, 2'd1, 1'b0, "R5 same");
    // R6: load in execute, decode uses its destination on B
    drive(mk(8, 1, 7, 1, 1, 0, 1), mk(7, 5, 0, 1, 0, 1, 1), BUB, BUB, 2'd0, 2'd0, 1'b1, "R6 loadUseB");
    // R7: matching source not used
    drive(mk(8, 1, 7, 1, 0, 0, 1), mk(7, 5, 0, 1, 0, 1, 1), BUB, BUB, 2'd0, 2'd0, 1'b0, "R7 unused");
    // R7: producer in execute is not a load
    drive(mk(8, 7, 1, 1, 1, 0, 1), mk(7, 5, 6, 1, 1, 0, 1), BUB, BUB, 2'd0, 2'd0, 1'b0, "R7 notLoad");
    // R7: load into register 0
    drive(mk(8, 0, 1, 1, 1, 0, 1), mk(0, 5, 0, 1, 0, 1, 1), BUB, BUB, 2'd0, 2'd0, 1'b0, "R7 zeroLoad");
    // R6 with R1 in the same cycle: stall plus forward to the load's base
    drive(mk(8, 7, 1, 1, 1, 0, 1), mk(7, 2, 0, 1, 0, 1, 1), mk(2, 0, 0, 0, 0, 0, 1), BUB,
          2'd1, 2'd0, 1'b1, "R6 stallAndFwd");

    // R9: LD r1 ; ADD r2,r1,r3 ; SUB r4,r2,r1 ; next
    wait (q.size() == 0);
    @(negedge clk);
    base = stallSeen;
    drive(mk(2, 1, 3, 1, 1, 0, 1), mk(1, 5, 0, 1, 0, 1, 1), BUB, BUB, 2'd0, 2'd0, 1'b1, "R9 c0");
    drive(mk(2, 1, 3, 1, 1, 0, 1), BUB, mk(1, 5, 0, 1, 0, 1, 1), BUB, 2'd0, 2'd0, 1'b0, "R9 c1");
    drive(mk(4, 2, 1, 1, 1, 0, 1), mk(2, 1, 3, 1, 1, 0, 1), BUB, mk(1, 5, 0, 1, 0, 1, 1),
          2'd3, 2'd0, 1'b0, "R9 c2");
    drive(mk(6, 9, 9, 1, 1, 0, 1), mk(4, 2, 1, 1, 1, 0, 1), mk(2, 1, 3, 1, 1, 0, 1), BUB,
          2'd1, 2'd0, 1'b0, "R9 c3");
    wait (q.size() == 0);
    @(negedge clk);
    #1;
    check("R9", "stallCycles", stallSeen - base, 1);

    // R10: ADD r5 ; SUB r6,r5,r5 back to back, no stall
    base = stallSeen;
    drive(mk(6, 5, 5, 1, 1, 0, 1), mk(5, 1, 2, 1, 1, 0, 1), BUB, BUB, 2'd0, 2'd0, 1'b0, "R10 c0");
    drive(BUB, mk(6, 5, 5, 1, 1, 0, 1), mk(5, 1, 2, 1, 1, 0, 1), BUB, 2'd1, 2'd1, 1'b0, "R10 c1");
    wait (q.size() == 0);
    @(negedge clk);
    #1;
    check("R10", "stallCycles", stallSeen - base, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule